// File: doc/BRIEF.md
# Second-Operand Shifter and Constant Expander

This unit forms the second operand that a datapath ALU consumes, together with the carry that the shift or rotate produces. A two-bit form code selects one of three sources. The first source is an 8-bit constant taken from a 12-bit operand field and rotated right by an even amount. The second is a register value shifted by a 5-bit amount taken from that same field. The third is a register value shifted by an amount read from the low byte of a second register. Four shift kinds are supported: shift left, logical shift right, arithmetic shift right and rotate right. A left rotate is not needed, because rotating right by 32 minus n gives the same result.

The first ALU operand never passes through this unit. The result and the carry are registered, so they appear one clock after the inputs are applied. The carry rule is as follows. Carry-out is the last bit moved out of the word. When the effective amount is zero, the incoming carry flag passes through unchanged.

Top module: `op2_shifter`

## Requirements
- R1: While rst_n is low, operand_o and carry_o are 0. Otherwise, each result appears on operand_o and carry_o one clock edge after the inputs that produced it.
- R2: Form code 2'b00 (constant) takes the rotate count from field_i[11:8] and the constant from field_i[7:0]. operand_o is the zero-extended constant rotated right by twice the rotate count, which is an even amount from 0 to 30.
- R3: In the constant form, carry_o equals operand_o bit 31 when the rotate count is non-zero, and equals carry_i when the rotate count is zero.
- R4: Shift kind 2'b00 shifts left and fills with zeros. For amounts 1 to 31, carry_o is the last bit shifted out. At amount 32, operand_o is 0 and carry_o is bit 0 of the register. Above 32, both are 0.
- R5: Shift kind 2'b01 shifts right logically and fills with zeros. For amounts 1 to 31, carry_o is the last bit shifted out. At amount 32, operand_o is 0 and carry_o is bit 31 of the register. Above 32, both are 0.
- R6: Shift kind 2'b10 shifts right arithmetically and fills with copies of bit 31. For amounts of 32 or more, every bit of operand_o and carry_o equal bit 31 of the register.
- R7: Shift kind 2'b11 rotates right by the amount modulo 32. For any non-zero amount, including multiples of 32, carry_o equals operand_o bit 31.
- R8: In the two register forms, an effective amount of zero passes the register value unchanged and sets carry_o to carry_i, whatever the shift kind.
- R9: Form code 2'b01 takes a 5-bit amount from field_i[11:7]. Form 2'b10 takes the amount from rs_value_i[7:0], and rs_value_i[31:8] has no effect. Form 2'b11 behaves exactly as form 2'b01.
- R10: In the constant form, rm_value_i, rs_value_i and shift_kind_i have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_form_i | input | 2 | Source form: 00 constant, 01 shift by field amount, 10 shift by register amount, 11 same as 01 |
| shift_kind_i | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| field_i | input | 12 | Operand field (rotate count and constant, or 5-bit amount) |
| rm_value_i | input | 32 | Register value to be shifted |
| rs_value_i | input | 32 | Register whose low byte gives the shift amount |
| carry_i | input | 1 | Incoming carry flag |
| operand_o | output | 32 | Registered second operand |
| carry_o | output | 1 | Registered shifter carry-out |

## Verification
The constant path is run through all sixteen rotate counts with an all-ones byte and with a single-bit byte. The single-bit byte shows where each rotation lands, and the all-ones byte shows whether the carry tracks bit 31. Each shift kind is driven through the register-amount form at amounts 0, 1, 31, 32, 33 and 255, using values whose bit 31 is set in some cases and clear in others. These amounts separate the ordinary, exact-width and oversized cases, and the set or clear bit 31 shows whether the fill is zeros or sign copies. Random vectors across all four forms, with junk in the ignored inputs, check that the field amount, the low byte of the amount register and the constant are each taken from the right place.

// File: rtl/op2_pkg.sv
package op2_pkg;

    typedef enum logic [1:0] {
        KIND_SHL  = 2'b00,
        KIND_SHR  = 2'b01,
        KIND_SAR  = 2'b10,
        KIND_ROTR = 2'b11
    } shift_kind_e;

    typedef enum logic [1:0] {
        FORM_CONST = 2'b00,
        FORM_FAMT  = 2'b01,
        FORM_RAMT  = 2'b10,
        FORM_FAMT2 = 2'b11
    } src_form_e;

endpackage

// File: rtl/op2_const_expand.sv
module op2_const_expand #(
    parameter int DATA_W = 32,
    parameter int ROT_W  = 4,
    parameter int IMM_W  = 8
) (
    input  logic [ROT_W-1:0] rot_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             carry_i,
    output logic [DATA_W-1:0] value_o,
    output logic              carry_o
);
    localparam int AMT_W = ROT_W + 1;

    logic [DATA_W-1:0] base;
    logic [AMT_W-1:0]  amt;
    logic [AMT_W:0]    amt_inv;

    always_comb begin
        base    = DATA_W'(imm_i);
        amt     = {rot_i, 1'b0};
        amt_inv = (AMT_W+1)'(DATA_W) - {1'b0, amt};
        if (amt == '0) begin
            value_o = base;
            carry_o = carry_i;
        end else begin
            value_o = (base >> amt) | (base << amt_inv);
            carry_o = value_o[DATA_W-1];
        end
    end
endmodule

// File: rtl/op2_amount_sel.sv
module op2_amount_sel #(
    parameter int DATA_W  = 32,
    parameter int SHIMM_W = 5,
    parameter int SHREG_W = 8
) (
    input  logic [1:0]         form_i,
    input  logic [SHIMM_W-1:0] field_amt_i,
    input  logic [DATA_W-1:0]  rs_value_i,
    output logic [SHREG_W-1:0] amt_o
);
    import op2_pkg::*;

    always_comb begin
        if (src_form_e'(form_i) == FORM_RAMT) begin
            amt_o = rs_value_i[SHREG_W-1:0];
        end else begin
            amt_o = SHREG_W'(field_amt_i);
        end
    end
endmodule

// File: rtl/op2_shift_core.sv
module op2_shift_core #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] value_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic [1:0]        kind_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] value_o,
    output logic              carry_o
);
    import op2_pkg::*;

    localparam int LOG_W = $clog2(DATA_W);

    logic [DATA_W:0]        ext_l;
    logic [DATA_W:0]        ext_r;
    logic signed [DATA_W:0] ext_a;
    logic [LOG_W-1:0]       rot;
    logic [LOG_W:0]         rot_inv;
    logic [DATA_W-1:0]      rotated;

    always_comb begin
        ext_l   = {1'b0, value_i} << amt_i;
        ext_r   = {value_i, 1'b0} >> amt_i;
        ext_a   = $signed({value_i, 1'b0}) >>> amt_i;
        rot     = amt_i[LOG_W-1:0];
        rot_inv = (LOG_W+1)'(DATA_W) - {1'b0, rot};
        rotated = (value_i >> rot) | (value_i << rot_inv);

        value_o = value_i;
        carry_o = carry_i;
        if (amt_i != '0) begin
            unique case (shift_kind_e'(kind_i))
                KIND_SHL: begin
                    value_o = ext_l[DATA_W-1:0];
                    carry_o = ext_l[DATA_W];
                end
                KIND_SHR: begin
                    value_o = ext_r[DATA_W:1];
                    carry_o = ext_r[0];
                end
                KIND_SAR: begin
                    value_o = ext_a[DATA_W:1];
                    carry_o = ext_a[0];
                end
                KIND_ROTR: begin
                    value_o = rotated;
                    carry_o = rotated[DATA_W-1];
                end
                default: begin
                    value_o = value_i;
                    carry_o = carry_i;
                end
            endcase
        end
    end
endmodule

// File: rtl/op2_shifter.sv
module op2_shifter #(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 12,
    parameter int ROT_W   = 4,
    parameter int IMM_W   = 8,
    parameter int SHIMM_W = 5,
    parameter int SHREG_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         src_form_i,
    input  logic [1:0]         shift_kind_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic [DATA_W-1:0]  rm_value_i,
    input  logic [DATA_W-1:0]  rs_value_i,
    input  logic               carry_i,
    output logic [DATA_W-1:0]  operand_o,
    output logic               carry_o
);
    import op2_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] operand;
        logic              carry;
    } op2_state_t;

    logic [ROT_W-1:0]   rot_w;
    logic [IMM_W-1:0]   imm_w;
    logic [SHIMM_W-1:0] famt_w;
    logic [SHREG_W-1:0] amt_w;
    logic [DATA_W-1:0]  const_val;
    logic               const_carry;
    logic [DATA_W-1:0]  shift_val;
    logic               shift_carry;
    logic               is_const;
    op2_state_t         state_d;
    op2_state_t         state_q;

    assign rot_w    = field_i[FIELD_W-1 -: ROT_W];
    assign imm_w    = field_i[IMM_W-1:0];
    assign famt_w   = field_i[FIELD_W-1 -: SHIMM_W];
    assign is_const = (src_form_e'(src_form_i) == FORM_CONST);

    op2_const_expand #(
        .DATA_W(DATA_W), .ROT_W(ROT_W), .IMM_W(IMM_W)
    ) u_const (
        .rot_i   (rot_w),
        .imm_i   (imm_w),
        .carry_i (carry_i),
        .value_o (const_val),
        .carry_o (const_carry)
    );

    op2_amount_sel #(
        .DATA_W(DATA_W), .SHIMM_W(SHIMM_W), .SHREG_W(SHREG_W)
    ) u_amt (
        .form_i      (src_form_i),
        .field_amt_i (famt_w),
        .rs_value_i  (rs_value_i),
        .amt_o       (amt_w)
    );

    op2_shift_core #(
        .DATA_W(DATA_W), .AMT_W(SHREG_W)
    ) u_shift (
        .value_i (rm_value_i),
        .amt_i   (amt_w),
        .kind_i  (shift_kind_i),
        .carry_i (carry_i),
        .value_o (shift_val),
        .carry_o (shift_carry)
    );

    always_comb begin
        state_d = state_q;
        if (is_const) begin
            state_d.operand = const_val;
            state_d.carry   = const_carry;
        end else begin
            state_d.operand = shift_val;
            state_d.carry   = shift_carry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign operand_o = state_q.operand;
    assign carry_o   = state_q.carry;

    // R2: zero rotate count gives the plain constant and the incoming carry
    a_r2_const_plain: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(is_const) && $past(rot_w) == '0)
        |-> (operand_o == DATA_W'($past(imm_w)) && carry_o == $past(carry_i)));

    // R3: non-zero rotate count gives carry equal to result bit 31
    a_r3_const_carry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(is_const) && $past(rot_w) != '0)
        |-> (carry_o == operand_o[DATA_W-1]));

    // R4: shift left past the width clears result and carry
    a_r4_shl_beyond: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(is_const) && $past(shift_kind_i) == 2'b00
         && $past(amt_w) > SHREG_W'(DATA_W))
        |-> (operand_o == '0 && !carry_o));

    // R6: arithmetic shift at or past the width fills with the sign
    a_r6_sar_sat: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(is_const) && $past(shift_kind_i) == 2'b10
         && $past(amt_w) >= SHREG_W'(DATA_W))
        |-> (operand_o == {DATA_W{$past(rm_value_i[DATA_W-1])}}
             && carry_o == $past(rm_value_i[DATA_W-1])));

    // R7: rotate with non-zero amount gives carry equal to result bit 31
    a_r7_rotr_carry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(is_const) && $past(shift_kind_i) == 2'b11
         && $past(amt_w) != '0)
        |-> (carry_o == operand_o[DATA_W-1]));

    // R8: zero amount passes register and carry through
    a_r8_zero_amt: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(is_const) && $past(amt_w) == '0)
        |-> (operand_o == $past(rm_value_i) && carry_o == $past(carry_i)));

endmodule

// File: tb/op2_shifter_tb.sv
`timescale 1ns/1ps
module op2_shifter_tb_top;

    localparam int W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_form = 2'b01;
    logic [1:0]  kind = 2'b11;
    logic [11:0] field = 12'hFFF;
    logic [W-1:0] rm = 32'hDEADBEEF;
    logic [W-1:0] rs = 32'hFFFFFFFF;
    logic        cin = 1'b1;
    logic [W-1:0] op_out;
    logic        c_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    op2_shifter dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_form_i   (src_form),
        .shift_kind_i (kind),
        .field_i      (field),
        .rm_value_i   (rm),
        .rs_value_i   (rs),
        .carry_i      (cin),
        .operand_o    (op_out),
        .carry_o      (c_out)
    );

    // bit-serial model: one position per step, carry is the bit moved out
    function automatic logic [W:0] ref_shift(logic [W-1:0] x, int amt,
                                             logic [1:0] k, logic c);
        logic [W-1:0] y = x;
        logic cc = c;
        for (int i = 0; i < amt; i++) begin
            case (k)
                2'b00: begin cc = y[W-1]; y = {y[W-2:0], 1'b0}; end
                2'b01: begin cc = y[0];   y = {1'b0, y[W-1:1]}; end
                2'b10: begin cc = y[0];   y = {y[W-1], y[W-1:1]}; end
                default: begin cc = y[0]; y = {y[0], y[W-1:1]}; end
            endcase
        end
        return {cc, y};
    endfunction

    function automatic logic [W:0] ref_model(logic [1:0] f, logic [1:0] k,
            logic [11:0] fld, logic [W-1:0] x, logic [W-1:0] s, logic c);
        if (f == 2'b00)
            return ref_shift({24'd0, fld[7:0]}, 2 * int'(fld[11:8]), 2'b11, c);
        else if (f == 2'b10)
            return ref_shift(x, int'(s[7:0]), k, c);
        else
            return ref_shift(x, int'(fld[11:7]), k, c);
    endfunction

    task automatic run_vec(logic [1:0] f, logic [1:0] k, logic [11:0] fld,
                           logic [W-1:0] x, logic [W-1:0] s, logic c,
                           string req);
        logic [W:0] exp_v;
        src_form = f; kind = k; field = fld; rm = x; rs = s; cin = c;
        exp_v = ref_model(f, k, fld, x, s, c);
        @(negedge clk);
        checks++;
        if (op_out !== exp_v[W-1:0] || c_out !== exp_v[W]) begin
            errors++;
            $display("FAIL %s form=%b kind=%b field=%h rm=%h rs=%h cin=%b: got %h/%b expected %h/%b",
                     req, f, k, fld, x, s, c, op_out, c_out, exp_v[W-1:0], exp_v[W]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int dummy;
        int amts [6] = '{0, 1, 31, 32, 33, 255};
        logic [W-1:0] pats [3] = '{32'h80000001, 32'h7FFFFFFE, 32'hC3A5_0F18};
        dummy = $urandom(32'h5EED_0042);

        // R1: reset state while inputs are busy
        repeat (3) @(negedge clk);
        checks++;
        if (op_out !== '0 || c_out !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got %h/%b expected 0/0", op_out, c_out);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3: every rotate count, two constants, both carry values
        for (int r = 0; r < 16; r++) begin
            run_vec(2'b00, 2'b00, {r[3:0], 8'hFF}, 32'h0, 32'h0, 1'b0, "R2/R3");
            run_vec(2'b00, 2'b01, {r[3:0], 8'h01}, 32'h0, 32'h0, 1'b1, "R2/R3");
        end

        // R4 R5 R6 R7 R8: each kind at the corner amounts via register amount
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 6; a++) begin
                for (int p = 0; p < 3; p++) begin
                    string tag;
                    case (k)
                        0: tag = "R4";
                        1: tag = "R5";
                        2: tag = "R6";
                        default: tag = "R7";
                    endcase
                    if (amts[a] == 0) tag = "R8";
                    run_vec(2'b10, k[1:0], 12'h000, pats[p],
                            {24'hABCDEF, amts[a][7:0]}, p[0], tag);
                end
            end
        end

        // R9: field amount forms, including 0, 1 and 31, and form 11
        for (int k = 0; k < 4; k++) begin
            run_vec(2'b01, k[1:0], {5'd0, 7'h55}, 32'h9000_0003, 32'h1F, 1'b1, "R9");
            run_vec(2'b01, k[1:0], {5'd1, 7'h2A}, 32'h9000_0003, 32'h00, 1'b0, "R9");
            run_vec(2'b11, k[1:0], {5'd31, 7'h7F}, 32'h9000_0003, 32'h01, 1'b0, "R9");
        end

        // R10: constant form ignores register inputs and shift kind
        run_vec(2'b00, 2'b11, 12'h4C3, 32'hFFFFFFFF, 32'h0000_0004, 1'b1, "R10");
        run_vec(2'b00, 2'b10, 12'h4C3, 32'h12345678, 32'hFFFF_FF20, 1'b0, "R10");

        // random mix over all forms
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] low;
            low = $urandom();
            if (i % 4 == 0) low = low & 8'h3F;
            run_vec($urandom_range(3, 0), $urandom_range(3, 0), $urandom(),
                    $urandom(), {$urandom_range(32'hFFFFFF, 0)[23:0], low},
                    $urandom_range(1, 0), "R2-R9 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule